// File: doc/BRIEF.md
# Run-Ahead Checkpoint and Invalid-Value Tracker

This block lets a simple in-order core keep executing while a data-cache load miss is outstanding. The first load that misses takes a snapshot of the whole architectural register file into a shadow copy and latches that load's program counter. The core then keeps retiring instructions speculatively. Every value that cannot be known yet is flagged: each register carries an unknown flag, and each cache line carries one too. The flags spread through arithmetic ops, loads and stores, each under its own rule. Speculative stores never reach memory, and exceptions are dropped.

When the miss returns, every register is reloaded from the snapshot in a single cycle and all flags are cleared. The latched program counter is then presented so fetch can restart at the missing load. Later misses during speculation become prefetch requests and do not take a new snapshot. A mode input, captured in the first cycle after reset, chooses what happens at a branch whose condition register is unknown. In cautious mode speculation halts there. In bold mode it carries on past the branch.

Decode, the ALU, the cache arrays and memory all sit outside the block. The block sees each retired op as a set of fields: its kind, its register indices, its result, a hit flag, a cache-line index and an exception flag.

Top module: `runahead_ckpt`

## Requirements
- R1: After reset the block is idle (`busy_o`=0, `halted_o`=0), every register reads 0 with its unknown flag clear, and `mode_aggr_i` is captured in the first cycle after the internal reset releases.
- R2: While idle, a retired load (`op_kind_i`=1) with `dc_hit_i`=0 starts speculation on the next cycle. It copies all registers into the snapshot, latches `op_pc_i`, flags the load's destination unknown and does not write its data.
- R3: During speculation an arithmetic op (`op_kind_i`=0) writes `op_data_i` to its destination and sets the destination flag to the OR of the flags of `src_a_i` and `src_b_i`.
- R4: During speculation a load writes `op_data_i` to its destination and flags it unknown if its address register (`src_a_i`) is unknown, if it misses, or if line `line_i` carries the unknown flag.
- R5: During speculation a store (`op_kind_i`=2) flags line `line_i` only when its address register is known and `dc_hit_i`=1. `store_commit_o` is raised for a store only while idle.
- R6: `exc_o` follows `exc_i` for a valid op only while idle. It stays 0 during speculation and while halted.
- R7: In cautious mode (captured mode 0), a branch (`op_kind_i`=3) whose condition register `src_a_i` is unknown moves the block to halted. While halted, retired ops change no register and no flag.
- R8: In bold mode (captured mode 1), a branch on an unknown register does not halt, and speculation goes on.
- R9: `miss_done_i` while busy raises `restart_o` in that same cycle, with `restart_pc_o` equal to the latched PC. On the next cycle every register holds its snapshot value, all register and line flags are clear and the block is idle. Any op in that cycle is ignored.
- R10: A load miss during speculation does not take a new snapshot and leaves the latched PC unchanged. If its address register is known it raises `prefetch_o` in that cycle.
- R11: While idle, arithmetic ops and load hits write `op_data_i` to the destination, and `miss_done_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_aggr_i | input | 1 | 1 = continue past unknown branches, 0 = halt there |
| op_valid_i | input | 1 | A retired op is presented |
| op_kind_i | input | 2 | 0 arithmetic, 1 load, 2 store, 3 branch |
| op_pc_i | input | PC_W | Program counter of the op |
| src_a_i | input | IDX_W | First source; address register for memory ops, condition register for branches |
| src_b_i | input | IDX_W | Second source register |
| dst_i | input | IDX_W | Destination register |
| op_data_i | input | XLEN | Result to write |
| dc_hit_i | input | 1 | Data-cache access hit |
| line_i | input | LINE_W | Cache line touched by a memory op |
| exc_i | input | 1 | Op raised an exception |
| miss_done_i | input | 1 | Outstanding miss has been serviced |
| rd_idx_i | input | IDX_W | Register read index |
| rd_data_o | output | XLEN | Register value at rd_idx_i |
| rd_inv_o | output | 1 | Unknown flag of register rd_idx_i |
| busy_o | output | 1 | Speculation active (running or halted) |
| halted_o | output | 1 | Speculation halted at an unknown branch |
| restart_o | output | 1 | Restart fetch this cycle |
| restart_pc_o | output | PC_W | Restart address |
| store_commit_o | output | 1 | Store may update memory |
| exc_o | output | 1 | Exception reported to the core |
| prefetch_o | output | 1 | Speculative miss issued as a prefetch |

## Verification
The register-flag rules are tried with ops whose sources are all known, partly unknown and fully unknown. This separates the OR rule from an AND rule or a first-source-only rule. Loads are tried under four conditions: a known address that hits a clean line, a known address that misses, an unknown address, and a hit on a line that an earlier speculative store flagged. Each condition isolates one term of the load rule. Stores with a known address and a hit, with an unknown address, and with a miss show that only the first sets a line flag. The same branch sequence is run after one reset in each mode. After restart, a hit on the previously flagged line reads back as known, which shows that the line flags were cleared.

// File: rtl/runahead_pkg.sv
package runahead_pkg;
  typedef enum logic [1:0] {
    OP_ALU    = 2'd0,
    OP_LOAD   = 2'd1,
    OP_STORE  = 2'd2,
    OP_BRANCH = 2'd3
  } op_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HALT = 2'd2
  } ra_state_e;
endpackage

// File: rtl/ra_ctrl.sv
module ra_ctrl
  import runahead_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_aggr_i,
  input  logic            start_i,
  input  logic [PC_W-1:0] start_pc_i,
  input  logic            branch_inv_i,
  input  logic            done_i,
  output logic            rst_int_n,
  output ra_state_e       state_o,
  output logic [PC_W-1:0] saved_pc_o
);
  logic [1:0]      sync_q;
  logic            init_q, init_d;
  logic            aggr_q, aggr_d, aggr_en;
  ra_state_e       st_q, st_d;
  logic [PC_W-1:0] pc_q, pc_d;
  logic            pc_en;

  // reset synchronizer: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_int_n = sync_q[1];

  always_comb begin
    init_d  = 1'b0;
    aggr_en = init_q;
    aggr_d  = mode_aggr_i;
    pc_en   = (st_q == ST_IDLE) && start_i;
    pc_d    = start_pc_i;
    st_d    = st_q;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = ST_RUN;
      ST_RUN: begin
        if (done_i)                       st_d = ST_IDLE;
        else if (branch_inv_i && !aggr_q) st_d = ST_HALT;
      end
      ST_HALT: if (done_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      init_q <= 1'b1;
      aggr_q <= 1'b0;
      st_q   <= ST_IDLE;
      pc_q   <= '0;
    end else begin
      init_q <= init_d;
      st_q   <= st_d;
      if (aggr_en) aggr_q <= aggr_d;
      if (pc_en)   pc_q   <= pc_d;
    end
  end

  assign state_o    = st_q;
  assign saved_pc_o = pc_q;

  a_r2_enter_run: assert property (@(posedge clk) disable iff (!rst_int_n)
    (st_q == ST_IDLE && start_i) |=> (st_q == ST_RUN));
  a_r7_halt_only_cautious: assert property (@(posedge clk) disable iff (!rst_int_n)
    (st_q == ST_HALT) |-> !aggr_q);
  a_r10_pc_held: assert property (@(posedge clk) disable iff (!rst_int_n)
    (st_q != ST_IDLE) |=> $stable(pc_q));
  a_r9_exit_idle: assert property (@(posedge clk) disable iff (!rst_int_n)
    (st_q != ST_IDLE && done_i) |=> (st_q == ST_IDLE));
endmodule

// File: rtl/ra_regfile.sv
module ra_regfile #(
  parameter int XLEN  = 16,
  parameter int NREGS = 8,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [XLEN-1:0]  wr_data_i,
  input  logic             inv_we_i,
  input  logic             inv_val_i,
  input  logic             snap_i,
  input  logic             restore_i,
  input  logic [IDX_W-1:0] ra_idx_i,
  input  logic [IDX_W-1:0] rb_idx_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             ra_inv_o,
  output logic             rb_inv_o,
  output logic [XLEN-1:0]  rd_data_o,
  output logic             rd_inv_o
);
  logic [NREGS-1:0][XLEN-1:0] rf_q, rf_d, bk_q;
  logic [NREGS-1:0]           inv_q, inv_d;

  always_comb begin
    rf_d  = rf_q;
    inv_d = inv_q;
    if (restore_i) begin
      rf_d  = bk_q;
      inv_d = '0;
    end else begin
      if (wr_en_i)  rf_d[wr_idx_i]  = wr_data_i;
      if (inv_we_i) inv_d[wr_idx_i] = inv_val_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf_q  <= '0;
      bk_q  <= '0;
      inv_q <= '0;
    end else begin
      rf_q  <= rf_d;
      inv_q <= inv_d;
      if (snap_i) bk_q <= rf_q;
    end
  end

  assign ra_inv_o  = inv_q[ra_idx_i];
  assign rb_inv_o  = inv_q[rb_idx_i];
  assign rd_data_o = rf_q[rd_idx_i];
  assign rd_inv_o  = inv_q[rd_idx_i];

  a_r9_flags_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    restore_i |=> (inv_q == '0));
  a_r9_regs_restored: assert property (@(posedge clk) disable iff (!rst_n)
    restore_i |=> (rf_q == $past(bk_q)));
  a_r2_snapshot_taken: assert property (@(posedge clk) disable iff (!rst_n)
    snap_i |=> (bk_q == $past(rf_q)));
  a_r2_no_write_on_snap: assert property (@(posedge clk) disable iff (!rst_n)
    snap_i |-> !wr_en_i);
endmodule

// File: rtl/ra_line_flags.sv
module ra_line_flags #(
  parameter int NLINES = 16,
  localparam int LINE_W = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_i,
  input  logic [LINE_W-1:0] set_idx_i,
  input  logic              clr_all_i,
  input  logic [LINE_W-1:0] rd_idx_i,
  output logic              rd_flag_o
);
  logic [NLINES-1:0] flags;

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic bit_q, bit_d;
    always_comb begin
      bit_d = bit_q;
      if (clr_all_i)                                        bit_d = 1'b0;
      else if (set_i && (set_idx_i == LINE_W'(g)))          bit_d = 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bit_q <= 1'b0;
      else        bit_q <= bit_d;
    end
    assign flags[g] = bit_q;
  end

  assign rd_flag_o = flags[rd_idx_i];

  a_r9_lines_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all_i |=> (flags == '0));
  a_r5_single_line_set: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_all_i |=> ($countones(flags & ~$past(flags)) <= 1));
endmodule

// File: rtl/runahead_ckpt.sv
module runahead_ckpt
  import runahead_pkg::*;
#(
  parameter int XLEN   = 16,
  parameter int NREGS  = 8,
  parameter int PC_W   = 16,
  parameter int NLINES = 16,
  localparam int IDX_W  = $clog2(NREGS),
  localparam int LINE_W = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_aggr_i,
  input  logic              op_valid_i,
  input  logic [1:0]        op_kind_i,
  input  logic [PC_W-1:0]   op_pc_i,
  input  logic [IDX_W-1:0]  src_a_i,
  input  logic [IDX_W-1:0]  src_b_i,
  input  logic [IDX_W-1:0]  dst_i,
  input  logic [XLEN-1:0]   op_data_i,
  input  logic              dc_hit_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              exc_i,
  input  logic              miss_done_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [XLEN-1:0]   rd_data_o,
  output logic              rd_inv_o,
  output logic              busy_o,
  output logic              halted_o,
  output logic              restart_o,
  output logic [PC_W-1:0]   restart_pc_o,
  output logic              store_commit_o,
  output logic              exc_o,
  output logic              prefetch_o
);
  op_kind_e  kind;
  ra_state_e st;
  logic      rst_int_n;
  logic      idle, running;
  logic      is_alu, is_load, is_store, is_branch;
  logic      start, spec, restore, branch_inv;
  logic      inv_a, inv_b, line_bad;
  logic      wr_en, inv_we, inv_val, line_set;
  logic [PC_W-1:0] saved_pc;

  assign kind      = op_kind_e'(op_kind_i);
  assign is_alu    = (kind == OP_ALU);
  assign is_load   = (kind == OP_LOAD);
  assign is_store  = (kind == OP_STORE);
  assign is_branch = (kind == OP_BRANCH);

  assign idle    = (st == ST_IDLE);
  assign running = (st == ST_RUN);

  assign start      = idle && op_valid_i && is_load && !dc_hit_i;
  assign spec       = running && op_valid_i && !miss_done_i;
  assign restore    = !idle && miss_done_i;
  assign branch_inv = spec && is_branch && inv_a;

  always_comb begin
    wr_en    = (idle && op_valid_i && (is_alu || (is_load && dc_hit_i)))
             || (spec && (is_alu || is_load));
    inv_we   = start || (spec && (is_alu || is_load));
    if (start)       inv_val = 1'b1;
    else if (is_alu) inv_val = inv_a || inv_b;
    else             inv_val = inv_a || !dc_hit_i || line_bad;
    line_set = spec && is_store && !inv_a && dc_hit_i;
  end

  ra_ctrl #(.PC_W(PC_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_aggr_i  (mode_aggr_i),
    .start_i      (start),
    .start_pc_i   (op_pc_i),
    .branch_inv_i (branch_inv),
    .done_i       (miss_done_i),
    .rst_int_n    (rst_int_n),
    .state_o      (st),
    .saved_pc_o   (saved_pc)
  );

  ra_regfile #(.XLEN(XLEN), .NREGS(NREGS)) u_rf (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en_i   (wr_en),
    .wr_idx_i  (dst_i),
    .wr_data_i (op_data_i),
    .inv_we_i  (inv_we),
    .inv_val_i (inv_val),
    .snap_i    (start),
    .restore_i (restore),
    .ra_idx_i  (src_a_i),
    .rb_idx_i  (src_b_i),
    .rd_idx_i  (rd_idx_i),
    .ra_inv_o  (inv_a),
    .rb_inv_o  (inv_b),
    .rd_data_o (rd_data_o),
    .rd_inv_o  (rd_inv_o)
  );

  ra_line_flags #(.NLINES(NLINES)) u_lines (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .set_i     (line_set),
    .set_idx_i (line_i),
    .clr_all_i (restore),
    .rd_idx_i  (line_i),
    .rd_flag_o (line_bad)
  );

  assign busy_o         = !idle;
  assign halted_o       = (st == ST_HALT);
  assign restart_o      = restore;
  assign restart_pc_o   = saved_pc;
  assign store_commit_o = idle && op_valid_i && is_store;
  assign exc_o          = idle && op_valid_i && exc_i;
  assign prefetch_o     = spec && is_load && !dc_hit_i && !inv_a;

  a_r5_no_commit_busy: assert property (@(posedge clk) disable iff (!rst_int_n)
    busy_o |-> !store_commit_o);
  a_r6_exc_quiet_busy: assert property (@(posedge clk) disable iff (!rst_int_n)
    busy_o |-> !exc_o);
  a_r10_prefetch_running: assert property (@(posedge clk) disable iff (!rst_int_n)
    prefetch_o |-> (busy_o && !halted_o && !restart_o));
  a_r7_halted_frozen: assert property (@(posedge clk) disable iff (!rst_int_n)
    (halted_o && !miss_done_i) |=> (halted_o && $stable(restart_pc_o)));
endmodule

// File: tb/runahead_ckpt_tb.sv
`timescale 1ns/100ps
module runahead_ckpt_tb_top;
  localparam int XLEN = 16, NREGS = 8, PC_W = 16, NLINES = 16;
  localparam int IDX_W = $clog2(NREGS), LINE_W = $clog2(NLINES);

  logic clk = 1'b0;
  logic rst_n, mode_aggr_i, op_valid_i, dc_hit_i, exc_i, miss_done_i;
  logic [1:0] op_kind_i;
  logic [PC_W-1:0] op_pc_i, restart_pc_o;
  logic [IDX_W-1:0] src_a_i, src_b_i, dst_i, rd_idx_i;
  logic [XLEN-1:0] op_data_i, rd_data_o;
  logic [LINE_W-1:0] line_i;
  logic rd_inv_o, busy_o, halted_o, restart_o, store_commit_o, exc_o, prefetch_o;

  always #2.5 clk = ~clk;

  runahead_ckpt dut_i (.*);

  int checks = 0, errors = 0, ptr = 0;
  int m_rf[NREGS], m_bk[NREGS];
  bit m_inv[NREGS], m_linv[NLINES];
  int m_st, m_pc;
  bit m_aggr;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset(bit mode);
    foreach (m_rf[i]) begin m_rf[i] = 0; m_bk[i] = 0; m_inv[i] = 0; end
    foreach (m_linv[i]) m_linv[i] = 0;
    m_st = 0; m_pc = 0; m_aggr = mode;
  endtask

  task automatic do_reset(bit mode);
    mode_aggr_i = mode; op_valid_i = 0; op_kind_i = 0; op_pc_i = 0;
    src_a_i = 0; src_b_i = 0; dst_i = 0; op_data_i = 0; dc_hit_i = 0;
    line_i = 0; exc_i = 0; miss_done_i = 0; rd_idx_i = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (5) @(posedge clk);
    model_reset(mode);
  endtask

  // one cycle: drive, check combinational outputs, then advance the model at the edge
  task automatic step(string tag, bit v, int k, int a, int b, int d, int data,
                      bit hit, int line, bit ex, int pc, bit done);
    bit spec, ia, ib;
    int ri;
    @(negedge clk);
    op_valid_i = v; op_kind_i = k[1:0]; src_a_i = a[IDX_W-1:0];
    src_b_i = b[IDX_W-1:0]; dst_i = d[IDX_W-1:0]; op_data_i = data[XLEN-1:0];
    dc_hit_i = hit; line_i = line[LINE_W-1:0]; exc_i = ex;
    op_pc_i = pc[PC_W-1:0]; miss_done_i = done;
    ri = ptr; ptr = (ptr + 1) % NREGS; rd_idx_i = ri[IDX_W-1:0];
    #1;
    spec = (m_st == 1) && v && !done;
    check({tag, " data"}, rd_data_o, m_rf[ri]);
    check({tag, " flag"}, rd_inv_o, m_inv[ri]);
    check("R2 busy", busy_o, m_st != 0);
    check("R7 halted", halted_o, m_st == 2);
    check("R9 restart", restart_o, (m_st != 0) && done);
    if ((m_st != 0) && done) check("R9 restart pc", restart_pc_o, m_pc);
    check("R5 commit", store_commit_o, (m_st == 0) && v && (k == 2));
    check("R6 exc", exc_o, (m_st == 0) && v && ex);
    check("R10 prefetch", prefetch_o, spec && (k == 1) && !hit && !m_inv[a]);
    @(posedge clk);
    ia = m_inv[a]; ib = m_inv[b];
    case (m_st)
      0: begin
        if (v && k == 1 && !hit) begin
          foreach (m_rf[i]) m_bk[i] = m_rf[i];
          m_pc = pc; m_inv[d] = 1; m_st = 1;
        end else if (v && (k == 0 || (k == 1 && hit))) m_rf[d] = data & 16'hffff;
      end
      default: begin
        if (done) begin
          foreach (m_rf[i]) begin m_rf[i] = m_bk[i]; m_inv[i] = 0; end
          foreach (m_linv[i]) m_linv[i] = 0;
          m_st = 0;
        end else if (m_st == 1 && v) begin
          case (k)
            0: begin m_rf[d] = data & 16'hffff; m_inv[d] = ia | ib; end
            1: begin m_rf[d] = data & 16'hffff; m_inv[d] = ia | !hit | m_linv[line]; end
            2: if (!ia && hit) m_linv[line] = 1;
            default: if (!m_aggr && ia) m_st = 2;
          endcase
        end
      end
    endcase
  endtask

  task automatic idle_scan(string tag, bit done);
    for (int i = 0; i < NREGS; i++) step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, done);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // cautious mode
    do_reset(1'b0);
    idle_scan("R1 reset", 0);
    step("R11 alu", 1, 0, 0, 0, 1, 'h11, 1, 0, 0, 'h10, 0);
    step("R11 alu", 1, 0, 0, 0, 2, 'h22, 1, 0, 0, 'h12, 0);
    step("R11 alu", 1, 0, 0, 0, 3, 'h33, 1, 0, 0, 'h14, 0);
    step("R11 ldhit", 1, 1, 1, 0, 4, 'h44, 1, 2, 0, 'h16, 0);
    step("R5 idle store", 1, 2, 1, 0, 0, 0, 1, 2, 0, 'h18, 0);
    step("R6 idle exc", 1, 0, 0, 0, 7, 'h77, 1, 0, 1, 'h1a, 0);
    idle_scan("R11 done idle", 1);
    step("R2 trigger", 1, 1, 3, 0, 5, 'hdead, 0, 1, 0, 'h100, 0);
    idle_scan("R2 snapshot", 0);
    step("R6 spec exc", 1, 0, 1, 2, 7, 'h700, 1, 0, 1, 'h104, 0);
    step("R5 spec store", 1, 2, 1, 0, 0, 0, 1, 9, 0, 'h106, 0);
    step("R3 one unknown", 1, 0, 5, 1, 6, 'h600, 1, 0, 0, 'h108, 0);
    step("R3 both known", 1, 0, 1, 2, 7, 'h701, 1, 0, 0, 'h10a, 0);
    step("R3 both unknown", 1, 0, 5, 6, 0, 'h0aa, 1, 0, 0, 'h10c, 0);
    step("R4 unknown addr", 1, 1, 5, 0, 1, 'h101, 1, 2, 0, 'h10e, 0);
    step("R10 second miss", 1, 1, 3, 0, 2, 'h202, 0, 6, 0, 'h110, 0);
    step("R10 miss bad addr", 1, 1, 5, 0, 0, 'h0bb, 0, 6, 0, 'h112, 0);
    step("R5 store set", 1, 2, 3, 0, 0, 0, 1, 3, 0, 'h114, 0);
    step("R5 store bad addr", 1, 2, 5, 0, 0, 0, 1, 4, 0, 'h116, 0);
    step("R5 store miss", 1, 2, 3, 0, 0, 0, 0, 5, 0, 'h118, 0);
    step("R4 flagged line", 1, 1, 4, 0, 3, 'h303, 1, 3, 0, 'h11a, 0);
    step("R4 clean line", 1, 1, 4, 0, 0, 'h0cc, 1, 4, 0, 'h11c, 0);
    step("R4 miss line", 1, 1, 4, 0, 0, 'h0cd, 1, 5, 0, 'h11e, 0);
    idle_scan("R4 scan", 0);
    step("R7 known branch", 1, 3, 7, 0, 0, 0, 1, 0, 0, 'h120, 0);
    step("R7 unknown branch", 1, 3, 6, 0, 0, 0, 1, 0, 0, 'h122, 0);
    step("R7 halted op", 1, 0, 1, 2, 7, 'h999, 1, 0, 0, 'h124, 0);
    step("R7 halted load", 1, 1, 4, 0, 4, 'h998, 1, 3, 0, 'h126, 0);
    idle_scan("R7 frozen", 0);
    step("R9 restart", 1, 0, 1, 2, 7, 'h555, 1, 0, 0, 'h128, 1);
    idle_scan("R9 restored", 0);
    step("R9 retrigger", 1, 1, 1, 0, 6, 'h666, 0, 0, 0, 'h200, 0);
    step("R9 line cleared", 1, 1, 4, 0, 3, 'h313, 1, 3, 0, 'h202, 0);
    idle_scan("R9 line scan", 0);
    step("R9 restart2", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    idle_scan("R9 restored2", 0);
    // bold mode
    do_reset(1'b1);
    idle_scan("R1 reset bold", 0);
    step("R8 trigger", 1, 1, 0, 0, 2, 'h1, 0, 0, 0, 'h300, 0);
    step("R8 unknown branch", 1, 3, 2, 0, 0, 0, 1, 0, 0, 'h302, 0);
    step("R8 continues", 1, 0, 2, 0, 3, 'h123, 1, 0, 0, 'h304, 0);
    step("R8 continues", 1, 0, 0, 1, 4, 'h124, 1, 0, 0, 'h306, 0);
    idle_scan("R8 scan", 0);
    step("R8 restart", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    idle_scan("R8 restored", 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule